// File: doc/BRIEF.md
# Byte-to-10-bit Line Encoder with Disparity Override

This block turns a byte and a control flag into a 10-bit DC-balanced code group, one symbol per clock. The byte is split into a low five-bit part x (bits 4:0) and a high three-bit part y (bits 7:5). The x part is mapped to a six-bit sub-block and the y part to a four-bit sub-block. For each sub-block the encoder picks the variant that pulls the line back toward zero, using the running disparity it keeps across symbols.

The running disparity is held as a two-state machine with states `RD_NEG` and `RD_POS`. On each accepted symbol it takes one of three transitions. `KEEP` applies when the symbol is balanced overall, so the state stays where it was. `FLIP` applies when the symbol is unbalanced, so the state moves to the other side. `FORCE` applies when the force-disparity input is high: the starting disparity for that symbol comes from the forced value instead of the state, and the state then follows the result of that symbol. On idle cycles the state takes no transition.

The code group, the valid flag and an illegal-control flag are registered, so the result appears one cycle after the input. The running disparity is exposed as a port.

Top module: `line_enc8b10b`

## Requirements
- R1: A symbol accepted with `in_valid` high at a rising edge appears on `out_code`, with `out_valid` high, right after that same edge. `out_valid` is low after every edge at which `in_valid` was low.
- R2: `out_code[9:4]` is the six-bit sub-block and `out_code[3:0]` is the four-bit sub-block. Data byte 0xB5 starting from negative disparity gives 0x2AA, and data byte 0x00 gives 0x274.
- R3: After reset, `rd_now` is 0, `out_valid` is 0 and `out_code` is 0. A `rd_now` value of 0 means negative disparity and 1 means positive.
- R4: Every code group has 4, 5 or 6 ones. An unbalanced sub-block always has the opposite sign to the disparity entering it.
- R5: After each valid symbol, `rd_now` gives the disparity after the four-bit sub-block. It is 1 after a code group with six ones and 0 after a code group with four ones.
- R6: With `in_k` high, the legal control bytes are x=28 with any y, and x in {23,27,29,30} with y=7. A legal control byte emits its control code group. Byte 0xBC gives 0x0FA from negative disparity and 0x305 from positive disparity.
- R7: With `in_k` high and a byte that is not a legal control byte, `out_kerr` goes high alongside the code group, and the code group is the data encoding of that byte (0x65 from negative disparity gives 0x29C). `out_kerr` is low for any symbol sent with `in_k` low.
- R8: With `force_en` high, the symbol is encoded from the disparity given by `force_rd` (1 means positive) and the tracked state is ignored.
- R9: After a forced symbol, tracking continues from the disparity that the forced symbol produced.
- R10: For y=7 data bytes, the alternate four-bit form is used in two cases: x in {17,18,20} with negative disparity entering the sub-block, and x in {11,13,14} with positive disparity entering it. Byte 0xF1 from negative disparity gives 0x237, and byte 0xEB from positive disparity gives 0x348.
- R11: While `in_valid` is low, the data, control and force inputs have no effect: `out_code` and `rd_now` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Symbol strobe |
| in_data | input | 8 | Byte to encode |
| in_k | input | 1 | Control-symbol flag |
| force_en | input | 1 | Use `force_rd` as the starting disparity |
| force_rd | input | 1 | Forced starting disparity, 1 = positive |
| out_code | output | 10 | Registered code group |
| out_valid | output | 1 | Code group is new this cycle |
| out_kerr | output | 1 | Control flag was set with an illegal byte |
| rd_now | output | 1 | Current running disparity, 1 = positive |

## Verification
The bench builds the block with its default `FORCE_SUPPORT` = 1, so the override mux is present. This lets a forced positive start be applied while the tracker is negative, and the reverse, to show that tracking then continues from the forced result. Fixed golden symbols cover both disparity sides of a control code, both alternate-form cases of the y=7 data codes, and an illegal control byte. A long stretch of random data, control, illegal-control and forced symbols with idle gaps of junk input follows, and the bench compares it with its own encoder model.

// File: rtl/enc_pkg.sv
package enc_pkg;
    localparam int BYTE_W = 8;
    localparam int X_W    = 5;
    localparam int Y_W    = 3;
    localparam int SUB6_W = 6;
    localparam int SUB4_W = 4;
    localparam int CODE_W = SUB6_W + SUB4_W;

    typedef enum logic {RD_NEG = 1'b0, RD_POS = 1'b1} rd_e;

    // Six-bit sub-block as sent from negative disparity
    function automatic logic [SUB6_W-1:0] d6_neg(input logic [X_W-1:0] x);
        logic [SUB6_W-1:0] c;
        unique case (x)
            5'd0:  c = 6'b100111;
            5'd1:  c = 6'b011101;
            5'd2:  c = 6'b101101;
            5'd3:  c = 6'b110001;
            5'd4:  c = 6'b110101;
            5'd5:  c = 6'b101001;
            5'd6:  c = 6'b011001;
            5'd7:  c = 6'b111000;
            5'd8:  c = 6'b111001;
            5'd9:  c = 6'b100101;
            5'd10: c = 6'b010101;
            5'd11: c = 6'b110100;
            5'd12: c = 6'b001101;
            5'd13: c = 6'b101100;
            5'd14: c = 6'b011100;
            5'd15: c = 6'b010111;
            5'd16: c = 6'b011011;
            5'd17: c = 6'b100011;
            5'd18: c = 6'b010011;
            5'd19: c = 6'b110010;
            5'd20: c = 6'b001011;
            5'd21: c = 6'b101010;
            5'd22: c = 6'b011010;
            5'd23: c = 6'b111010;
            5'd24: c = 6'b110011;
            5'd25: c = 6'b100110;
            5'd26: c = 6'b010110;
            5'd27: c = 6'b110110;
            5'd28: c = 6'b001110;
            5'd29: c = 6'b101110;
            5'd30: c = 6'b011110;
            default: c = 6'b101011;
        endcase
        return c;
    endfunction

    // Four-bit sub-block as sent from negative disparity (primary form)
    function automatic logic [SUB4_W-1:0] d4_neg(input logic [Y_W-1:0] y);
        logic [SUB4_W-1:0] c;
        unique case (y)
            3'd0: c = 4'b1011;
            3'd1: c = 4'b1001;
            3'd2: c = 4'b0101;
            3'd3: c = 4'b1100;
            3'd4: c = 4'b1101;
            3'd5: c = 4'b1010;
            3'd6: c = 4'b0110;
            default: c = 4'b1110;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/enc_kclass.sv
module enc_kclass
    import enc_pkg::*;
(
    input  logic [BYTE_W-1:0] data,
    input  logic              k_req,
    output logic              k_legal,
    output logic              k_bad,
    output logic              k_is28
);
    logic [X_W-1:0] x;
    logic [Y_W-1:0] y;
    logic           alt_k;

    assign x = data[X_W-1:0];
    assign y = data[BYTE_W-1:X_W];

    always_comb begin
        alt_k   = (y == 3'd7) &&
                  ((x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30));
        k_is28  = k_req && (x == 5'd28);
        k_legal = k_is28 || (k_req && alt_k);
        k_bad   = k_req && !k_legal;
    end
endmodule

// File: rtl/enc_sub6.sv
module enc_sub6
    import enc_pkg::*;
(
    input  logic [X_W-1:0]    x,
    input  logic              k28,
    input  rd_e               rd_in,
    output logic [SUB6_W-1:0] code6,
    output rd_e               rd_mid
);
    logic [SUB6_W-1:0] base;
    logic              flip;

    always_comb begin
        base = k28 ? 6'b001111 : d6_neg(x);
        flip = (rd_in == RD_POS) &&
               (($countones(base) != 3) || (base == 6'b111000));
        code6 = flip ? ~base : base;
        if ($countones(code6) > 3)      rd_mid = RD_POS;
        else if ($countones(code6) < 3) rd_mid = RD_NEG;
        else                            rd_mid = rd_in;
    end
endmodule

// File: rtl/enc_sub4.sv
module enc_sub4
    import enc_pkg::*;
(
    input  logic [Y_W-1:0]    y,
    input  logic [X_W-1:0]    x,
    input  logic              k_legal,
    input  rd_e               rd_mid,
    output logic [SUB4_W-1:0] code4,
    output rd_e               rd_out
);
    logic [SUB4_W-1:0] base;
    logic              use_alt;
    logic              unbal;

    always_comb begin
        use_alt = k_legal ||
                  ((rd_mid == RD_NEG) && ((x == 5'd17) || (x == 5'd18) || (x == 5'd20))) ||
                  ((rd_mid == RD_POS) && ((x == 5'd11) || (x == 5'd13) || (x == 5'd14)));
        base = d4_neg(y);
        if ((y == 3'd7) && use_alt) base = 4'b0111;
        unbal = ($countones(base) != 2) || (base == 4'b1100);
        if (unbal)
            code4 = (rd_mid == RD_POS) ? ~base : base;
        else if (k_legal && (rd_mid == RD_NEG))
            code4 = ~base;
        else
            code4 = base;
        if ($countones(code4) > 2)      rd_out = RD_POS;
        else if ($countones(code4) < 2) rd_out = RD_NEG;
        else                            rd_out = rd_mid;
    end
endmodule

// File: rtl/line_enc8b10b.sv
module line_enc8b10b
    import enc_pkg::*;
#(
    parameter bit FORCE_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_k,
    input  logic              force_en,
    input  logic              force_rd,
    output logic [CODE_W-1:0] out_code,
    output logic              out_valid,
    output logic              out_kerr,
    output logic              rd_now
);
    rd_e               rd_q, rd_d, rd_start, rd_mid, rd_out;
    logic              k_legal, k_bad, k_is28;
    logic [SUB6_W-1:0] code6;
    logic [SUB4_W-1:0] code4;

    generate
        if (FORCE_SUPPORT) begin : g_force
            always_comb rd_start = force_en ? rd_e'(force_rd) : rd_q;
        end else begin : g_noforce
            logic unused_force;
            assign unused_force = force_en ^ force_rd;
            always_comb rd_start = rd_q;
        end
    endgenerate

    enc_kclass u_kclass (
        .data    (in_data),
        .k_req   (in_k),
        .k_legal (k_legal),
        .k_bad   (k_bad),
        .k_is28  (k_is28)
    );

    enc_sub6 u_sub6 (
        .x      (in_data[X_W-1:0]),
        .k28    (k_is28),
        .rd_in  (rd_start),
        .code6  (code6),
        .rd_mid (rd_mid)
    );

    enc_sub4 u_sub4 (
        .y       (in_data[BYTE_W-1:X_W]),
        .x       (in_data[X_W-1:0]),
        .k_legal (k_legal),
        .rd_mid  (rd_mid),
        .code4   (code4),
        .rd_out  (rd_out)
    );

    // Running-disparity state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= RD_NEG;
        else        rd_q <= rd_d;
    end

    // Transitions: KEEP (idle or balanced), FLIP (unbalanced), FORCE (override start)
    always_comb begin
        rd_d = rd_q;
        if (in_valid) begin
            unique case (rd_out)
                RD_NEG: rd_d = RD_NEG;
                RD_POS: rd_d = RD_POS;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_code  <= '0;
            out_valid <= 1'b0;
            out_kerr  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_code <= {code6, code4};
                out_kerr <= k_bad;
            end
        end
    end

    assign rd_now = (rd_q == RD_POS);
endmodule

// File: rtl/line_enc8b10b_chk.sv
module line_enc8b10b_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       force_on,
    input logic       in_valid,
    input logic       in_k,
    input logic       force_en,
    input logic       force_rd,
    input logic [9:0] out_code,
    input logic       out_valid,
    input logic       out_kerr,
    input logic       rd_now
);
    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4
    balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_code) >= 4 && $countones(out_code) <= 6));
    // R5
    rd_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_code) == 6) |-> rd_now);
    // R5
    rd_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_code) == 4) |-> !rd_now);
    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(rd_now));
    // R11
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_code));
    // R7
    kerr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_k) |=> !out_kerr);
    // R8
    force_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_on && in_valid && force_en && !force_rd) |=> ($countones(out_code[9:4]) >= 3));
    // R8
    force_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_on && in_valid && force_en && force_rd) |=> ($countones(out_code[9:4]) <= 3));
endmodule

bind line_enc8b10b line_enc8b10b_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_on  (FORCE_SUPPORT),
    .in_valid  (in_valid),
    .in_k      (in_k),
    .force_en  (force_en),
    .force_rd  (force_rd),
    .out_code  (out_code),
    .out_valid (out_valid),
    .out_kerr  (out_kerr),
    .rd_now    (rd_now)
);

// File: tb/line_enc8b10b_bench.sv
`timescale 1ns/1ps
module line_enc8b10b_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_k = 1'b0;
    logic       force_en = 1'b0;
    logic       force_rd = 1'b0;
    logic [9:0] out_code;
    logic       out_valid;
    logic       out_kerr;
    logic       rd_now;

    always #2.5 clk = ~clk;

    line_enc8b10b u_line_enc8b10b (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_k(in_k), .force_en(force_en), .force_rd(force_rd),
        .out_code(out_code), .out_valid(out_valid), .out_kerr(out_kerr),
        .rd_now(rd_now)
    );

    typedef struct {
        logic [9:0] code;
        logic       kerr;
        logic       rd;
        bit         has_gold;
        logic [9:0] gold;
        string      tag;
    } item_t;

    item_t      sb[$];
    int         checks = 0;
    int         errors = 0;
    logic       exp_rd = 1'b0;
    logic       mon_rd = 1'b0;
    logic [9:0] last_code = 10'h000;
    bit         running = 1'b0;
    bit         reported = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] m6(input logic [4:0] x);
        logic [5:0] t[32];
        t = '{6'h27, 6'h1D, 6'h2D, 6'h31, 6'h35, 6'h29, 6'h19, 6'h38,
              6'h39, 6'h25, 6'h15, 6'h34, 6'h0D, 6'h2C, 6'h1C, 6'h17,
              6'h1B, 6'h23, 6'h13, 6'h32, 6'h0B, 6'h2A, 6'h1A, 6'h3A,
              6'h33, 6'h26, 6'h16, 6'h36, 6'h0E, 6'h2E, 6'h1E, 6'h2B};
        return t[x];
    endfunction

    function automatic logic [3:0] m4(input logic [2:0] y);
        logic [3:0] t[8];
        t = '{4'hB, 4'h9, 4'h5, 4'hC, 4'hD, 4'hA, 4'h6, 4'hE};
        return t[y];
    endfunction

    function automatic logic [9:0] model(input logic [7:0] d, input logic k,
                                         input logic rd, output logic rd_o,
                                         output logic bad);
        logic [4:0] x;
        logic [2:0] y;
        logic       legal, r, alt;
        logic [5:0] s6;
        logic [3:0] s4;
        x = d[4:0];
        y = d[7:5];
        legal = k && (x == 5'd28 || (y == 3'd7 &&
                 (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30)));
        bad = k && !legal;
        s6 = (legal && x == 5'd28) ? 6'b001111 : m6(x);
        if (rd && ($countones(s6) != 3 || s6 == 6'b111000)) s6 = ~s6;
        r = ($countones(s6) > 3) ? 1'b1 : ($countones(s6) < 3) ? 1'b0 : rd;
        alt = legal || (!r && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
              (r && (x == 5'd11 || x == 5'd13 || x == 5'd14));
        s4 = m4(y);
        if (y == 3'd7 && alt) s4 = 4'b0111;
        if ($countones(s4) != 2 || s4 == 4'b1100) begin
            if (r) s4 = ~s4;
        end else if (legal && !r) begin
            s4 = ~s4;
        end
        rd_o = ($countones(s4) > 2) ? 1'b1 : ($countones(s4) < 2) ? 1'b0 : r;
        return {s6, s4};
    endfunction

    // Driver: called at a falling edge, returns at the next falling edge
    task automatic send(input logic [7:0] d, input logic k, input logic fe,
                        input logic fr, input bit hg, input logic [9:0] g,
                        input string tag);
        item_t it;
        logic  st, ro, bd;
        in_valid = 1'b1;
        in_data  = d;
        in_k     = k;
        force_en = fe;
        force_rd = fr;
        st = fe ? fr : exp_rd;
        it.code = model(d, k, st, ro, bd);
        it.kerr = bd;
        it.rd   = ro;
        it.has_gold = hg;
        it.gold = g;
        it.tag  = tag;
        exp_rd  = ro;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            in_data  = 8'($urandom);
            in_k     = 1'($urandom);
            force_en = 1'($urandom);
            force_rd = 1'($urandom);
            @(negedge clk);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (running) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1", "unexpected output", 1, 0);
                end else begin
                    item_t e;
                    e = sb.pop_front();
                    check(out_code == e.code, e.tag, "code", out_code, e.code);
                    if (e.has_gold)
                        check(out_code == e.gold, e.tag, "golden code", out_code, e.gold);
                    check(out_kerr == e.kerr, "R7", "kerr", out_kerr, e.kerr);
                    check(rd_now == e.rd, "R5", "rd_now", rd_now, e.rd);
                    check($countones(out_code) >= 4 && $countones(out_code) <= 6,
                          "R4", "ones count", $countones(out_code), 5);
                    mon_rd    = e.rd;
                    last_code = out_code;
                end
            end else begin
                check(out_code == last_code, "R11", "code hold", out_code, last_code);
                check(rd_now == mon_rd, "R11", "rd hold", rd_now, mon_rd);
            end
        end
    end

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3 reset state
        check(rd_now == 1'b0, "R3", "rd_now in reset", rd_now, 0);
        check(out_valid == 1'b0, "R3", "out_valid in reset", out_valid, 0);
        check(out_code == 10'h000, "R3", "out_code in reset", out_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1'b1;

        send(8'hBC, 1'b1, 1'b0, 1'b0, 1'b1, 10'h0FA, "R6");
        send(8'hBC, 1'b1, 1'b0, 1'b0, 1'b1, 10'h305, "R6");
        send(8'hB5, 1'b0, 1'b0, 1'b0, 1'b1, 10'h2AA, "R2");
        send(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 10'h274, "R2");
        send(8'hF1, 1'b0, 1'b0, 1'b0, 1'b1, 10'h237, "R10");
        send(8'hEB, 1'b0, 1'b0, 1'b0, 1'b1, 10'h348, "R10");
        idle(3);
        // R8: forced positive while tracker is negative
        send(8'hBC, 1'b1, 1'b1, 1'b1, 1'b1, 10'h305, "R8");
        send(8'hF1, 1'b0, 1'b0, 1'b0, 1'b1, 10'h237, "R9");
        // R8: forced negative while tracker is positive; R9 continue from result
        send(8'hBC, 1'b1, 1'b1, 1'b0, 1'b1, 10'h0FA, "R8");
        send(8'hEB, 1'b0, 1'b0, 1'b0, 1'b1, 10'h348, "R9");
        // R7 illegal control byte
        send(8'h65, 1'b1, 1'b0, 1'b0, 1'b1, 10'h29C, "R7");
        idle(2);

        for (int i = 0; i < 600; i++) begin
            int unsigned sel;
            logic [7:0]  d;
            logic        k;
            sel = $urandom_range(0, 9);
            d = 8'($urandom);
            k = 1'b0;
            if (sel == 0) begin
                k = 1'b1;
                d = {3'($urandom), 5'd28};
            end else if (sel == 1) begin
                int unsigned p;
                p = $urandom_range(0, 3);
                k = 1'b1;
                d = {3'd7, (p == 0) ? 5'd23 : (p == 1) ? 5'd27 : (p == 2) ? 5'd29 : 5'd30};
            end else if (sel == 2) begin
                k = 1'b1;
            end
            send(d, k, ($urandom_range(0, 7) == 0), 1'($urandom), 1'b0, 10'h000,
                 k ? "R6" : "R2");
            if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 3));
        end
        idle(4);
        check(sb.size() == 0, "R1", "pending items", sb.size(), 0);
        running = 1'b0;
        finish_run();
    end
endmodule